// File: doc/BRIEF.md
# Fractional Duty to Edge-Position Converter

This block turns a per-unit duty value into the compare word that a high-resolution PWM edge placer consumes. It multiplies an unsigned Q15 duty by the coarse period in clock counts. The integer part of that product becomes the coarse compare count. The leftover fraction is scaled by a runtime count of delay-line steps per clock, rounded to the nearest step, and becomes the fine position. Both parts leave in one 32-bit word, so a single write updates the coarse and fine edge together.

A second mode serves callers that have already split the product. These callers supply a word whose upper half is the coarse count and whose bits 15:8 are the fraction as a Q8 value. The block then applies only the step scaling and the rounding. The scale factor is an input that calibration code may change slowly. The block samples it together with each request.

The conversion runs in three register stages and accepts a new request on every clock. Each request yields exactly one result. The result word holds its value until the next result replaces it.

Top module: `frac_edge_conv`

## Requirements
- R1: In direct mode (`auto_mode`=0), out_word[31:16] equals floor(d*period/32768), where d is duty_q15 limited to 0x7FFF.
- R2: In direct mode, with f = (d*period) mod 32768, out_word[15:8] equals floor((f*scale + 16384)/32768). For example, duty 13271 with period 80 and scale 55 gives 0x00201600.
- R3: out_word[7:0] is always zero.
- R4: In prescaled mode (`auto_mode`=1), out_word[31:16] equals cmp_in[31:16] and out_word[15:8] equals floor((cmp_in[15:8]*scale + 128)/256). cmp_in[7:0] has no effect.
- R5: out_valid is high for one clock per request, three clocks after in_valid is sampled high. Requests on consecutive clocks give results on consecutive clocks, in order.
- R6: While out_valid is low, out_word keeps its last value.
- R7: The fine byte saturates at 255 and never carries into the coarse field. Duty 0x7FFF with period 1 and scale 255 gives 0x0000FF00.
- R8: A duty_q15 value above 0x7FFF gives the same result as 0x7FFF.
- R9: During reset and after it, until the first result, out_valid is 0 and out_word is 0.
- R10: Mode, duty, period, cmp_in and scale are sampled only on a clock where in_valid is high. Later changes do not alter a request already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| auto_mode | input | 1 | 1 selects prescaled mode, 0 selects direct mode |
| duty_q15 | input | 16 | Unsigned Q15 duty, direct mode |
| period | input | 16 | Coarse period in clock counts, direct mode |
| cmp_in | input | 32 | Coarse count and Q8 fraction, prescaled mode |
| scale | input | 8 | Delay-line steps per clock |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Coarse compare in 31:16, fine steps in 15:8 |

## Verification
A wrong fraction or rounding term shows up as a fine byte that is one step off. The bench therefore uses duties whose scaled fraction lies near half a step, as well as worked values, and compares each result against an independent model. A lost or doubled pipeline valid shows up on the very result strobe it affects: a result that comes early, comes late or is missing breaks the three-cycle spacing, or leaves the queue of expected results unbalanced. A stage that loads while idle, or a sampled scale that follows the port, changes the word in a cycle where it must hold. The bench catches this within one clock.

// File: rtl/frac_edge_conv.sv
module frac_edge_conv #(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int SW = 8,
  parameter int FW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                auto_mode,
  input  logic [DW-1:0]       duty_q15,
  input  logic [PW-1:0]       period,
  input  logic [PW+2*FW-1:0]  cmp_in,
  input  logic [SW-1:0]       scale,
  output logic                out_valid,
  output logic [PW+2*FW-1:0]  out_word
);
  localparam int QB    = DW - 1;
  localparam int PRODW = QB + PW;
  localparam int SUMW  = QB + SW + 1;
  localparam int STW   = SUMW - QB;
  localparam int OW    = PW + 2*FW;
  localparam logic [SUMW-1:0] HALF = SUMW'(1) << (QB-1);

  logic [QB-1:0]    duty_lim;
  logic [PRODW-1:0] prod;
  logic [PW-1:0]    coarse_in;
  logic [QB-1:0]    frac_in;

  assign duty_lim  = duty_q15[DW-1] ? {QB{1'b1}} : duty_q15[QB-1:0];
  assign prod      = PRODW'(duty_lim) * PRODW'(period);
  assign coarse_in = auto_mode ? cmp_in[OW-1:2*FW] : prod[PRODW-1:QB];
  assign frac_in   = auto_mode ? {cmp_in[2*FW-1:FW], {(QB-FW){1'b0}}} : prod[QB-1:0];

  logic          v1, v2;
  logic [PW-1:0] coarse1, coarse2;
  logic [QB-1:0] frac1;
  logic [SW-1:0] scale1;
  logic [SUMW-1:0] sum2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      coarse1 <= '0;
      frac1 <= '0;
      scale1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        coarse1 <= coarse_in;
        frac1 <= frac_in;
        scale1 <= scale;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      coarse2 <= '0;
      sum2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        coarse2 <= coarse1;
        sum2 <= SUMW'(frac1) * SUMW'(scale1) + HALF;
      end
    end
  end

  logic [STW-1:0] steps;
  logic [FW-1:0]  fine;

  assign steps = sum2[SUMW-1:QB];
  assign fine  = (|steps[STW-1:FW]) ? {FW{1'b1}} : steps[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_word <= {coarse2, fine, {FW{1'b0}}};
    end
  end
endmodule

module frac_edge_conv_chk #(
  parameter int PW = 16,
  parameter int SW = 8,
  parameter int FW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               auto_mode,
  input logic [PW+2*FW-1:0] cmp_in,
  input logic [SW-1:0]      scale,
  input logic               out_valid,
  input logic [PW+2*FW-1:0] out_word
);
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));
  // R3
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[FW-1:0] == '0);
  // R4
  auto_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(auto_mode, 3)) |-> out_word[PW+2*FW-1:2*FW] == $past(cmp_in[PW+2*FW-1:2*FW], 3));
  // R2
  zero_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(scale, 3) == '0) |-> out_word[2*FW-1:FW] == '0);
endmodule

bind frac_edge_conv frac_edge_conv_chk #(.PW(PW), .SW(SW), .FW(FW)) u_chk (.*);

// File: tb/test_frac_edge_conv.sv
`timescale 1ns/1ps
module test_frac_edge_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        auto_mode = 1'b0;
  logic [15:0] duty_q15 = '0;
  logic [15:0] period = '0;
  logic [31:0] cmp_in = '0;
  logic [7:0]  scale = '0;
  logic        out_valid;
  logic [31:0] out_word;

  frac_edge_conv i_frac_edge_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .auto_mode(auto_mode),
    .duty_q15(duty_q15), .period(period), .cmp_in(cmp_in), .scale(scale),
    .out_valid(out_valid), .out_word(out_word)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit have_last = 0;
  logic [31:0] last_word = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(bit am, logic [15:0] d, logic [15:0] p,
                                        logic [31:0] c, logic [7:0] s);
    longint dl, pr, co, fr, fi;
    if (am) begin
      co = c[31:16];
      fi = (longint'(c[15:8]) * s + 128) >> 8;
    end else begin
      dl = (d > 16'h7FFF) ? 32767 : d;
      pr = dl * p;
      co = pr >> 15;
      fr = pr & 32'h7FFF;
      fi = (fr * s + 16384) >> 15;
    end
    if (fi > 255) fi = 255;
    return {co[15:0], fi[7:0], 8'h00};
  endfunction

  task automatic send(bit am, logic [15:0] d, logic [15:0] p, logic [31:0] c,
                      logic [7:0] s, string tag);
    @(negedge clk);
    in_valid = 1'b1; auto_mode = am; duty_q15 = d; period = p; cmp_in = c; scale = s;
    exp_q.push_back(model(am, d, p, c, s));
    tag_q.push_back(tag);
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected result", out_word, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          int c0;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          c0 = cyc_q.pop_front();
          chk(out_word === e, t, out_word, e);
          chk(cyc - c0 == 3, "R5 latency", 32'(cyc - c0), 32'd3);
        end
        last_word = out_word;
        have_last = 1;
      end else if (have_last) begin
        chk(out_word === last_word, "R6 hold", out_word, last_word);
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    chk(out_valid === 1'b0 && out_word === 32'h0, "R9 reset", out_word, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 after reset, before first result
    chk(out_valid === 1'b0 && out_word === 32'h0, "R9 post reset", out_word, 32'h0);
    started = 1;

    send(0, 16'd13271, 16'd80, 32'h0, 8'd55, "R1 R2 worked 0x00201600");
    idle(4);
    send(1, 16'h0, 16'h0, {16'd32, 8'd102, 8'hAB}, 8'd55, "R4 prescaled worked");
    idle(4);
    send(0, 16'h0000, 16'd500, 32'h0, 8'd55, "R1 zero duty");
    send(0, 16'h4000, 16'd1000, 32'h0, 8'd55, "R1 half duty");
    send(0, 16'h7FFF, 16'd1, 32'h0, 8'd255, "R7 saturation 0x0000FF00");
    send(0, 16'hFFFF, 16'd80, 32'h0, 8'd55, "R8 duty clamp");
    send(0, 16'h8001, 16'd65535, 32'h0, 8'd200, "R8 duty clamp wide");
    send(0, 16'h7FFF, 16'd65535, 32'h0, 8'd255, "R1 full period");
    send(1, 16'h0, 16'h0, {16'hFFFF, 8'hFF, 8'hFF}, 8'd255, "R7 prescaled top");
    send(1, 16'h0, 16'h0, {16'h1234, 8'h80, 8'h00}, 8'd0, "R2 R4 zero scale");
    send(0, 16'd16384, 16'd3, 32'h0, 8'd1, "R2 rounding half");
    idle(4);

    // R10: inputs move after acceptance
    send(0, 16'd13271, 16'd80, 32'h0, 8'd55, "R10 sampled scale");
    @(negedge clk);
    in_valid = 1'b0; scale = 8'd200; duty_q15 = 16'h7000; period = 16'd9; auto_mode = 1'b1;
    cmp_in = 32'hDEAD_BEEF;
    idle(5);

    // R5 back-to-back alternating mixed stream
    for (int k = 0; k < 60; k++) begin
      send(k[0], 16'($urandom), 16'($urandom), $urandom, 8'($urandom), "R1 R2 R4 R5 stream");
    end
    idle(8);

    chk(exp_q.size() == 0, "R5 drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule